// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a free-running watchdog timer that software cannot switch off once it has been started. A 12-bit down-counter runs on a divided copy of the block clock. Three magic values written to a 16-bit key port control it. One value opens the divider and reload settings for writing. One value refills the counter, which is how software "kicks" the watchdog. One value starts it. No key stops it. Only a system reset returns the block to idle.

When the counter has to step below zero, the block raises a reset request for a fixed number of clocks. It also sets a reset-cause flag. The flag is cleared only by a power-on reset or by an explicit clear strobe. Because of this, software can tell after the system reset that the watchdog caused it. The configuration registers and the live count can be read back on output ports.

Top module: `keyed_watchdog`

## Requirements
- R1: After a system reset (`rst_n` low), `running` is 0, `rst_req` is 0, `div_code` is 0, `reload_val` is 0xFFF and `count` is 0xFFF. After a power-on reset (`por_n` low), `cause_flag` is 0.
- R2: Writes on the divider port (`div_wr`) and the reload port (`reload_wr`) take effect only while the block is unlocked. Key 0x5555 unlocks it. A key write of any other value locks it again. Writes made while locked leave `div_code` and `reload_val` unchanged.
- R3: Key 0xCCCC sets `running` and loads `count` from `reload_val` at the same clock edge.
- R4: With reload value R and divider code p (0 to 6), `rst_req` first rises D*(R+1) clock edges after the start key edge, where D = 2^(p+2).
- R5: Divider codes 7 and above divide by 256, as code 6 does.
- R6: Key 0xAAAA reloads `count` from `reload_val` and restarts the divider phase. The next timeout therefore comes D*(R+1) edges after the kick.
- R7: Once `running` is set, no key value and no register write clears it. Only `rst_n` does.
- R8: Each timeout holds `rst_req` high for exactly RST_CYCLES clocks (4 by default).
- R9: A timeout sets `cause_flag`. The flag survives `rst_n` and is cleared by a `flag_clr` strobe or by `por_n`.
- R10: While running, `count` decreases by one every D clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed count clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset for the cause flag |
| key_wr | input | 1 | Key write strobe |
| key_data | input | 16 | Key value |
| div_wr | input | 1 | Divider code write strobe |
| div_data | input | 3 | Divider code to write |
| reload_wr | input | 1 | Reload value write strobe |
| reload_data | input | 12 | Reload value to write (tick count minus one) |
| flag_clr | input | 1 | Clears the reset-cause flag |
| running | output | 1 | Watchdog has been started |
| rst_req | output | 1 | Reset request pulse |
| cause_flag | output | 1 | A watchdog timeout has occurred |
| div_code | output | 3 | Stored divider code |
| reload_val | output | 12 | Stored reload value |
| count | output | 12 | Live counter value |

## Verification
The timeout path is driven with several pairs of divider code and reload value: code 0 with reload 3, code 2 with reload 1, code 6 with reload 1, and code 7 with reload 1. The first three separate a wrong power-of-two exponent from an off-by-one in the tick count. The fourth shows whether codes above 6 are clamped. Kicks in the middle of a count show whether the divider phase restarts along with the counter. Key sequences of unlock, a foreign value and then a write show whether locking again happens on every key write. Arbitrary key values on a running watchdog probe for any way to stop it. A system reset after a timeout separates the cause flag's reset domain from the rest.

// File: rtl/wdg_pkg.sv
// Package wdg_pkg
// Shared key constants and the divider-code decode for the watchdog.
// Assumes a 16-bit key port and a 3-bit divider code.
package wdg_pkg;
    localparam int KEY_W       = 16;
    localparam int DIV_CODE_W  = 3;
    localparam int DIV_MAX     = 6;
    localparam int DIV_CNT_W   = DIV_MAX + 2;

    localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_KICK   = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;

    // Terminal count (divisor minus one) for a divider code; codes above DIV_MAX clamp.
    function automatic logic [DIV_CNT_W-1:0] div_last(input logic [DIV_CODE_W-1:0] code);
        int eff;
        eff = (int'(code) > DIV_MAX) ? DIV_MAX : int'(code);
        return DIV_CNT_W'((1 << (eff + 2)) - 1);
    endfunction
endpackage

// File: rtl/wdg_key_unit.sv
// Module wdg_key_unit
// Decodes key writes into unlock, kick and start actions. Holds the
// write-protected divider and reload registers and the running state.
// Assumes that at most one strobe of each kind is active per clock.
module wdg_key_unit
    import wdg_pkg::*;
#(
    parameter int RLD_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  key_wr,
    input  logic [KEY_W-1:0]      key_data,
    input  logic                  div_wr,
    input  logic [DIV_CODE_W-1:0] div_data,
    input  logic                  reload_wr,
    input  logic [RLD_W-1:0]      reload_data,
    output logic [DIV_CODE_W-1:0] div_q,
    output logic [RLD_W-1:0]      rld_q,
    output logic                  running_q,
    output logic                  load
);
    logic unlock_q;
    logic key_start;
    logic key_kick;

    assign key_start = key_wr && (key_data == KEY_START);
    assign key_kick  = key_wr && (key_data == KEY_KICK);
    assign load      = key_start || key_kick;

    // Unlock state: set by the unlock key, cleared by any other key.
    always_ff @(posedge clk) begin
        if (!rst_n)      unlock_q <= 1'b0;
        else if (key_wr) unlock_q <= (key_data == KEY_UNLOCK);
    end

    // Protected configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            rld_q <= '1;
        end else begin
            if (div_wr && unlock_q)    div_q <= div_data;
            if (reload_wr && unlock_q) rld_q <= reload_data;
        end
    end

    // Running state: set by the start key, only a system reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         running_q <= 1'b0;
        else if (key_start) running_q <= 1'b1;
    end

    // R2
    locked_rld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_wr && !unlock_q) |=> $stable(rld_q));
    // R2
    locked_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr && !unlock_q) |=> $stable(div_q));
    // R7
    no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |=> running_q);
endmodule

// File: rtl/wdg_prescaler.sv
// Module wdg_prescaler
// Power-of-two clock divider that produces a one-clock tick every
// 2^(code+2) clocks while enabled. A restart clears the phase.
module wdg_prescaler
    import wdg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic                  run,
    input  logic [DIV_CODE_W-1:0] code,
    output logic                  tick
);
    logic [DIV_CNT_W-1:0] phase_q;
    logic [DIV_CNT_W-1:0] last;

    assign last = div_last(code);
    assign tick = run && !restart && (phase_q == last);

    // Divider phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase_q <= '0;
        else if (tick)         phase_q <= '0;
        else if (run)          phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/wdg_counter.sv
// Module wdg_counter
// 12-bit down-counter that steps once per tick. Stepping below zero
// raises an underflow strobe, refills the counter and starts a reset
// request pulse of RST_CYCLES clocks.
module wdg_counter #(
    parameter int RLD_W      = 12,
    parameter int RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             running,
    input  logic [RLD_W-1:0] rld,
    output logic [RLD_W-1:0] cnt_q,
    output logic             underflow,
    output logic             rst_req
);
    localparam int PW = $clog2(RST_CYCLES + 1);

    logic [PW-1:0] pulse_q;

    assign underflow = tick && running && !load && (cnt_q == '0);
    assign rst_req   = (pulse_q != '0);

    // Count register: load on a key, decrement on a tick, refill on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '1;
        else if (load)             cnt_q <= rld;
        else if (underflow)        cnt_q <= rld;
        else if (tick && running)  cnt_q <= cnt_q - 1'b1;
    end

    // Reset request pulse stretcher.
    always_ff @(posedge clk) begin
        if (!rst_n)                pulse_q <= '0;
        else if (underflow)        pulse_q <= PW'(RST_CYCLES);
        else if (pulse_q != '0)    pulse_q <= pulse_q - 1'b1;
    end

    // R4
    timeout_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> rst_req);
    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && running && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/keyed_watchdog.sv
// Module keyed_watchdog
// Top of the key-protected watchdog: key unit, divider, counter and a
// reset-cause flag held in the power-on reset domain, so it outlives
// the system reset that the watchdog requests.
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int RLD_W      = 12,
    parameter int RST_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  por_n,
    input  logic                  key_wr,
    input  logic [KEY_W-1:0]      key_data,
    input  logic                  div_wr,
    input  logic [DIV_CODE_W-1:0] div_data,
    input  logic                  reload_wr,
    input  logic [RLD_W-1:0]      reload_data,
    input  logic                  flag_clr,
    output logic                  running,
    output logic                  rst_req,
    output logic                  cause_flag,
    output logic [DIV_CODE_W-1:0] div_code,
    output logic [RLD_W-1:0]      reload_val,
    output logic [RLD_W-1:0]      count
);
    logic load;
    logic tick;
    logic underflow;

    wdg_key_unit #(.RLD_W(RLD_W)) u_keys (
        .clk(clk), .rst_n(rst_n),
        .key_wr(key_wr), .key_data(key_data),
        .div_wr(div_wr), .div_data(div_data),
        .reload_wr(reload_wr), .reload_data(reload_data),
        .div_q(div_code), .rld_q(reload_val),
        .running_q(running), .load(load)
    );

    wdg_prescaler u_div (
        .clk(clk), .rst_n(rst_n), .restart(load),
        .run(running), .code(div_code), .tick(tick)
    );

    wdg_counter #(.RLD_W(RLD_W), .RST_CYCLES(RST_CYCLES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .running(running), .rld(reload_val),
        .cnt_q(count), .underflow(underflow), .rst_req(rst_req)
    );

    // Reset-cause flag: set on timeout, cleared by strobe or power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n)         cause_flag <= 1'b0;
        else if (underflow) cause_flag <= 1'b1;
        else if (flag_clr)  cause_flag <= 1'b0;
    end

    // R9
    cause_set_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        underflow |=> cause_flag);
endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        key_wr = 1'b0;
    logic [15:0] key_data = '0;
    logic        div_wr = 1'b0;
    logic [2:0]  div_data = '0;
    logic        reload_wr = 1'b0;
    logic [11:0] reload_data = '0;
    logic        flag_clr = 1'b0;
    logic        running, rst_req, cause_flag;
    logic [2:0]  div_code;
    logic [11:0] reload_val, count;

    int n_checks = 0;
    int n_fail   = 0;

    keyed_watchdog #(.RLD_W(12), .RST_CYCLES(RST_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .key_wr(key_wr), .key_data(key_data),
        .div_wr(div_wr), .div_data(div_data),
        .reload_wr(reload_wr), .reload_data(reload_data),
        .flag_clr(flag_clr),
        .running(running), .rst_req(rst_req), .cause_flag(cause_flag),
        .div_code(div_code), .reload_val(reload_val), .count(count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sys_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic write_key(input logic [15:0] v);
        @(negedge clk) begin key_wr = 1'b1; key_data = v; end
        @(negedge clk) key_wr = 1'b0;
    endtask

    task automatic write_cfg(input logic [2:0] p, input logic [11:0] r);
        @(negedge clk) begin div_wr = 1'b1; div_data = p; reload_wr = 1'b1; reload_data = r; end
        @(negedge clk) begin div_wr = 1'b0; reload_wr = 1'b0; end
    endtask

    // Edges from the last key edge until rst_req is seen high.
    task automatic edges_to_req(output int k);
        k = 0;
        while (k < 5000) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (rst_req) break;
        end
    endtask

    task automatic t_reset_state();
        check("R1 running", running, 0);
        check("R1 rst_req", rst_req, 0);
        check("R1 div_code", div_code, 0);
        check("R1 reload_val", reload_val, 12'hFFF);
        check("R1 count", count, 12'hFFF);
        check("R1 cause_flag", cause_flag, 0);
    endtask

    task automatic t_lock();
        write_cfg(3'd5, 12'd9);
        check("R2 locked reload", reload_val, 12'hFFF);
        check("R2 locked div", div_code, 0);
        write_key(16'h5555);
        write_cfg(3'd0, 12'd3);
        check("R2 unlocked reload", reload_val, 3);
        write_key(16'h1234);
        write_cfg(3'd4, 12'd7);
        check("R2 relocked reload", reload_val, 3);
        check("R2 relocked div", div_code, 0);
    endtask

    task automatic t_start_timeout();
        int k;
        int len;
        write_key(16'hCCCC);
        check("R3 running", running, 1);
        check("R3 count loaded", count, 3);
        repeat (4) @(negedge clk);
        check("R10 count after one tick", count, 2);
        // Already 4 edges spent since the start key edge (plus 1 within write_key).
        edges_to_req(k);
        check("R4 code0 reload3 edges", k + 4, 16);
        check("R9 flag set", cause_flag, 1);
        len = 1;
        while (len < 20) begin
            @(negedge clk);
            if (rst_req) len++; else break;
        end
        check("R8 pulse length", len, RST_CYC);
    endtask

    task automatic t_no_stop();
        write_key(16'h0000);
        write_key(16'h5555);
        write_key(16'hFFFF);
        check("R7 still running", running, 1);
    endtask

    task automatic t_flag_domains();
        sys_reset();
        check("R9 flag survives rst_n", cause_flag, 1);
        check("R7 rst_n stops", running, 0);
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        check("R9 flag cleared", cause_flag, 0);
    endtask

    task automatic t_kick();
        int k;
        write_key(16'h5555);
        write_cfg(3'd0, 12'd3);
        write_key(16'hCCCC);
        repeat (10) @(negedge clk);
        write_key(16'hAAAA);
        check("R6 count reloaded", count, 3);
        edges_to_req(k);
        check("R6 edges after kick", k, 16);
    endtask

    task automatic t_divider(input logic [2:0] p, input int exp_edges, input string req);
        int k;
        sys_reset();
        write_key(16'h5555);
        write_cfg(p, 12'd1);
        write_key(16'hCCCC);
        edges_to_req(k);
        check(req, k, exp_edges);
    endtask

    task automatic t_por();
        @(negedge clk) por_n = 1'b0;
        @(negedge clk) por_n = 1'b1;
        check("R9 por clears flag", cause_flag, 0);
    endtask

    initial begin
        int wd;
        wd = 0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                por_n = 1'b1;
                t_reset_state();
                t_lock();
                t_start_timeout();
                t_no_stop();
                t_flag_domains();
                t_kick();
                t_divider(3'd2, 32, "R4 code2 reload1 edges");
                t_divider(3'd6, 512, "R4 code6 reload1 edges");
                t_divider(3'd7, 512, "R5 code7 clamps to 256");
                t_por();
            end
            begin
                repeat (100000) @(posedge clk);
                wd = 1;
            end
        join_any
        if (wd != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule